// File: doc/BRIEF.md
# Quad-Pumped Bus Transmitter with Per-Group Inversion

This block drives one agent's side of a shared 64-bit data path that carries four data sub-phases in every common clock. A local source hands it 256-bit beats over a valid/ready handshake. Each beat is cut into four 64-bit sub-phases, called slots, and each slot into four 16-bit groups. The block then puts all sixteen groups on the wire with their inversion flags and parity. Strobe generation and double-edge electrical timing are left out. The four slots of one common clock are presented side by side on a 256-bit registered lane port, with slot 0 as the first sub-phase.

All lanes are active-low: a logical 1 is driven as an electrical 0. To limit the number of lanes pulled low, a group is sent complemented when nine or more of its lanes would otherwise be low. Its active-low flag is then asserted. Every group carries its own parity bit. Data-ready marks each common clock that carries a beat. Bus-busy frames a transfer of one or more beats. Idle clocks appear with data-ready released when the source stalls partway through a transfer. After the final beat the bus is handed back, with a one-clock turnaround before the next transfer.

Top module: `qpump_tx`

## Requirements
- R1: A beat is taken on a rising edge where `in_valid` and `in_ready` are both high. In the following clock, slot s (0..3) of `bus_lane_n` (bits 64s+63..64s) carries `in_data` bits 64s+63..64s, and group g (0..3) of a slot is bits 16g+15..16g of that slot.
- R2: A group that is not inverted is driven as the bitwise complement of its logical data, so a logical 1 is an electrical 0.
- R3: A group is inverted only when its logical data holds 9 or more ones, that is, when 9 or more lanes would otherwise be low. A group with exactly 8 ones is not inverted.
- R4: Flag bit 4s+g of `bus_inv_n` is 0 exactly when group g of slot s is inverted, and an inverted group's lanes equal its logical data. The decision is made independently for every slot and group.
- R5: Parity bit 4s+g of `bus_par` makes the count of ones among the 16 wire lanes of that group, its flag bit and the parity bit even.
- R6: `bus_drdy_n` is 0 in exactly the clocks that follow an accepting edge, and 1 in all other clocks.
- R7: `bus_busy_n` is 0 from the clock that carries the first beat of a transfer through the clock that carries its last beat (`in_last` high), and 1 in the clock after the last beat.
- R8: When a transfer is open (a beat without `in_last` has been sent) and no beat is accepted on an edge, the next clock has `bus_drdy_n` = 1 and `bus_busy_n` = 0.
- R9: `in_ready` is 0 for the one clock that follows the acceptance of a last beat, and 1 at every other time after reset has been released.
- R10: In every clock without data-ready, all lanes, flags and parity bits are 1.
- R11: While `rst_n` is low, every bus output is 1 and `in_ready` is 0. After `rst_n` rises, `in_ready` becomes 1 after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| in_valid | input | 1 | Source offers a beat |
| in_ready | output | 1 | Block can take a beat on this edge |
| in_data | input | 256 | Beat, slot 0 in the low 64 bits |
| in_last | input | 1 | Offered beat closes the transfer |
| bus_lane_n | output | 256 | Active-low lanes for the four slots of this clock |
| bus_inv_n | output | 16 | Active-low inversion flags, bit 4*slot+group |
| bus_par | output | 16 | Even parity per group, bit 4*slot+group |
| bus_drdy_n | output | 1 | Active-low data-ready |
| bus_busy_n | output | 1 | Active-low bus-busy |

## Verification
The assertions assume that `in_valid`, `in_data` and `in_last` are stable around the rising edge. They also assume that `in_last` is only meaningful while `in_valid` is high. The bench changes inputs only on falling edges, and it lowers `in_valid` between beats, so a stall always shows up as a full clock without valid. The group patterns are built with chosen numbers of ones, so the counts 7, 8, 9, 0 and 16 all appear often, together with random data. Transfers of random length with random gaps open and close the bus many times.

// File: rtl/qpump_pkg.sv
package qpump_pkg;
  parameter int unsigned LANE_W_DEF  = 64;
  parameter int unsigned GROUP_W_DEF = 16;
  parameter int unsigned SLOTS_DEF   = 4;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_OPEN = 2'd1,
    XF_TURN = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/qpump_rst_sync.sv
module qpump_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/qpump_group_enc.sv
module qpump_group_enc #(
  parameter int unsigned GROUP_W = qpump_pkg::GROUP_W_DEF
) (
  input  logic [GROUP_W-1:0] word,
  output logic [GROUP_W-1:0] wire_lvl,
  output logic               flag_n,
  output logic               par
);
  localparam int unsigned CNT_W = $clog2(GROUP_W + 1);
  localparam int unsigned HALF  = GROUP_W / 2;

  logic [CNT_W-1:0] ones;
  logic             invert;

  always_comb begin
    ones = '0;
    for (int i = 0; i < GROUP_W; i++) begin
      ones = ones + CNT_W'(word[i]);
    end
  end

  // Strictly more than half low: equality keeps the plain encoding.
  assign invert   = (ones > CNT_W'(HALF));
  assign wire_lvl = invert ? word : ~word;
  assign flag_n   = ~invert;
  assign par      = ^{wire_lvl, flag_n};
endmodule

// File: rtl/qpump_slot_enc.sv
module qpump_slot_enc #(
  parameter int unsigned LANE_W  = qpump_pkg::LANE_W_DEF,
  parameter int unsigned GROUP_W = qpump_pkg::GROUP_W_DEF
) (
  input  logic [LANE_W-1:0]         slot_data,
  output logic [LANE_W-1:0]         slot_wire,
  output logic [LANE_W/GROUP_W-1:0] slot_flag_n,
  output logic [LANE_W/GROUP_W-1:0] slot_par
);
  localparam int unsigned GROUPS = LANE_W / GROUP_W;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    qpump_group_enc #(.GROUP_W(GROUP_W)) u_grp (
      .word     (slot_data[g*GROUP_W +: GROUP_W]),
      .wire_lvl (slot_wire[g*GROUP_W +: GROUP_W]),
      .flag_n   (slot_flag_n[g]),
      .par      (slot_par[g])
    );
  end
endmodule

// File: rtl/qpump_ctl.sv
module qpump_ctl
  import qpump_pkg::*;
(
  input  logic clk,
  input  logic rst_n_i,
  input  logic in_valid,
  input  logic in_last,
  output logic in_ready,
  output logic take,
  output logic drdy_n,
  output logic busy_n
);
  xfer_state_e state_q, state_d;
  logic        drdy_n_d, busy_n_d;

  always_comb begin
    in_ready = (state_q != XF_TURN);
    take     = in_valid & in_ready;
    state_d  = state_q;
    if (take) begin
      state_d = in_last ? XF_TURN : XF_OPEN;
    end else if (state_q == XF_TURN) begin
      state_d = XF_IDLE;
    end
    drdy_n_d = ~take;
    busy_n_d = ~(take | (state_q == XF_OPEN));
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= XF_TURN;
      drdy_n  <= 1'b1;
      busy_n  <= 1'b1;
    end else begin
      state_q <= state_d;
      drdy_n  <= drdy_n_d;
      busy_n  <= busy_n_d;
    end
  end

  // R7: data-ready never appears outside bus ownership
  p_drdy_inside_busy_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    !drdy_n |-> !busy_n);

  // R7: the last beat keeps busy for its clock, then releases
  p_release_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (take && in_last) |=> (!busy_n ##1 busy_n));

  // R9: turnaround clock refuses a beat
  p_turnaround_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (take && in_last) |=> !in_ready);

  // R8: a stall inside an open transfer holds the bus with no data
  p_stall_gap_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state_q == XF_OPEN && !in_valid) |=> (drdy_n && !busy_n));
endmodule

// File: rtl/qpump_tx.sv
module qpump_tx
  import qpump_pkg::*;
#(
  parameter int unsigned LANE_W  = LANE_W_DEF,
  parameter int unsigned GROUP_W = GROUP_W_DEF,
  parameter int unsigned SLOTS   = SLOTS_DEF
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [LANE_W*SLOTS-1:0]              in_data,
  input  logic                                 in_last,
  output logic [LANE_W*SLOTS-1:0]              bus_lane_n,
  output logic [(LANE_W/GROUP_W)*SLOTS-1:0]    bus_inv_n,
  output logic [(LANE_W/GROUP_W)*SLOTS-1:0]    bus_par,
  output logic                                 bus_drdy_n,
  output logic                                 bus_busy_n
);
  localparam int unsigned GROUPS = LANE_W / GROUP_W;
  localparam int unsigned BEAT_W = LANE_W * SLOTS;
  localparam int unsigned FLAG_W = GROUPS * SLOTS;

  logic              rst_n_i;
  logic              take;
  logic [BEAT_W-1:0] enc_wire;
  logic [FLAG_W-1:0] enc_flag_n, enc_par;
  logic [BEAT_W-1:0] lane_q, lane_d;
  logic [FLAG_W-1:0] flag_q, flag_d, par_q, par_d;
  logic              data_en;

  qpump_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  qpump_ctl u_ctl (
    .clk      (clk),
    .rst_n_i  (rst_n_i),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .take     (take),
    .drdy_n   (bus_drdy_n),
    .busy_n   (bus_busy_n)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    qpump_slot_enc #(.LANE_W(LANE_W), .GROUP_W(GROUP_W)) u_slot (
      .slot_data   (in_data[s*LANE_W +: LANE_W]),
      .slot_wire   (enc_wire[s*LANE_W +: LANE_W]),
      .slot_flag_n (enc_flag_n[s*GROUPS +: GROUPS]),
      .slot_par    (enc_par[s*GROUPS +: GROUPS])
    );
  end

  // Load on a beat; return to the resting level once after a data clock.
  always_comb begin
    data_en = take | ~bus_drdy_n;
    if (take) begin
      lane_d = enc_wire;
      flag_d = enc_flag_n;
      par_d  = enc_par;
    end else begin
      lane_d = '1;
      flag_d = '1;
      par_d  = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      lane_q <= '1;
      flag_q <= '1;
      par_q  <= '1;
    end else if (data_en) begin
      lane_q <= lane_d;
      flag_q <= flag_d;
      par_q  <= par_d;
    end
  end

  assign bus_lane_n = lane_q;
  assign bus_inv_n  = flag_q;
  assign bus_par    = par_q;

  for (genvar k = 0; k < FLAG_W; k++) begin : g_chk
    // R3: no group on the wire ever has more than half its lanes low
    p_low_bound_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
      $countones(lane_q[k*GROUP_W +: GROUP_W]) >= (GROUP_W / 2));

    // R5: lanes, flag and parity of one group hold an even count of ones
    p_even_parity_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
      ((^{lane_q[k*GROUP_W +: GROUP_W], flag_q[k], par_q[k]}) == 1'b0));
  end

  // R10: without data-ready every lane, flag and parity rests high
  p_idle_rest_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    bus_drdy_n |-> ((&lane_q) && (&flag_q) && (&par_q)));
endmodule

// File: tb/qpump_tx_test.sv
`timescale 1ns/1ps
module qpump_tx_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_last;
  logic [255:0] in_data;
  logic         in_ready;
  logic [255:0] bus_lane_n;
  logic [15:0]  bus_inv_n, bus_par;
  logic         bus_drdy_n, bus_busy_n;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 0;

  always #4 clk = ~clk;

  qpump_tx uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .bus_lane_n(bus_lane_n),
    .bus_inv_n(bus_inv_n), .bus_par(bus_par), .bus_drdy_n(bus_drdy_n),
    .bus_busy_n(bus_busy_n)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model, written from the requirements
  logic [255:0] m_lane;
  logic [15:0]  m_flag, m_par;
  logic         m_drdy_n, m_busy_n;
  bit           m_open, m_turn;
  bit [1:0]     m_sync;

  task automatic encode(input logic [255:0] d, output logic [255:0] ln,
                        output logic [15:0] fl, output logic [15:0] pr);
    for (int s = 0; s < 4; s++) begin
      for (int g = 0; g < 4; g++) begin
        logic [15:0] w, wl;
        int ones;
        bit inv;
        w = d[64*s + 16*g +: 16];
        ones = 0;
        for (int b = 0; b < 16; b++) ones += w[b];
        inv = (ones >= 9);
        wl = inv ? w : ~w;
        ln[64*s + 16*g +: 16] = wl;
        fl[4*s + g] = ~inv;
        pr[4*s + g] = ^{wl, ~inv};
      end
    end
  endtask

  task automatic m_rest();
    m_lane = '1; m_flag = '1; m_par = '1; m_drdy_n = 1; m_busy_n = 1;
    m_open = 0; m_turn = 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 2'b00;
      m_rest();
    end else begin
      if (!m_sync[1]) begin
        m_rest();
      end else begin
        bit acc;
        acc = in_valid && !m_turn;
        if (acc) begin
          encode(in_data, m_lane, m_flag, m_par);
          m_drdy_n = 0;
          m_busy_n = 0;
          m_open = !in_last;
          m_turn = in_last;
        end else begin
          m_lane = '1; m_flag = '1; m_par = '1;
          m_drdy_n = 1;
          m_busy_n = !m_open;
          m_turn = 0;
        end
      end
      m_sync = {m_sync[0], 1'b1};
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(bus_lane_n === m_lane, "R1/R2 lanes", bus_lane_n, m_lane);
      chk(bus_inv_n === m_flag, "R4 flags", {240'd0, bus_inv_n}, {240'd0, m_flag});
      chk(bus_par === m_par, "R5 parity", {240'd0, bus_par}, {240'd0, m_par});
      chk(bus_drdy_n === m_drdy_n, "R6 data-ready", {255'd0, bus_drdy_n}, {255'd0, m_drdy_n});
      chk(bus_busy_n === m_busy_n, "R7 bus-busy", {255'd0, bus_busy_n}, {255'd0, m_busy_n});
      chk(in_ready === !m_turn, "R9 ready", {255'd0, in_ready}, {255'd0, !m_turn});
    end
  end

  function automatic logic [15:0] group_k(input int k);
    logic [15:0] w;
    w = '0;
    while ($countones(w) < k) w[$urandom_range(15, 0)] = 1'b1;
    return w;
  endfunction

  function automatic logic [255:0] make_beat();
    logic [255:0] d;
    for (int i = 0; i < 16; i++) begin
      int sel;
      sel = $urandom_range(6, 0);
      case (sel)
        0: d[16*i +: 16] = group_k(7);
        1: d[16*i +: 16] = group_k(8);
        2: d[16*i +: 16] = group_k(9);
        3: d[16*i +: 16] = 16'h0000;
        4: d[16*i +: 16] = 16'hFFFF;
        default: d[16*i +: 16] = 16'($urandom);
      endcase
    end
    return d;
  endfunction

  task automatic send(input logic [255:0] d, input bit last);
    in_valid = 1; in_data = d; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  initial begin : watchdog
    #1200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1; in_valid = 0; in_last = 0; in_data = '0;
    #1 rst_n = 0;
    cmp_en = 1;
    repeat (3) @(negedge clk);
    // R11: reset state at the ports
    chk(bus_drdy_n && bus_busy_n && (&bus_lane_n) && (&bus_inv_n) && (&bus_par) && !in_ready,
        "R11 reset outputs", {254'd0, bus_drdy_n, in_ready}, {254'd0, 2'b10});
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(in_ready === 1'b0, "R11 ready held", {255'd0, in_ready}, 256'd0);
    @(negedge clk);
    chk(in_ready === 1'b1, "R11 ready released", {255'd0, in_ready}, 256'd1);

    // R3/R4: threshold at 8 and 9 ones in slot 0
    send({192'h0, 16'hFFFF, 16'h0000, 16'h01FF, 16'h00FF}, 1'b1);
    chk(bus_inv_n[3:0] === 4'b0101, "R3 threshold flags", {252'd0, bus_inv_n[3:0]}, 256'h5);
    chk(bus_lane_n[31:0] === 32'h01FF_FF00, "R4 inverted lanes",
        {224'd0, bus_lane_n[31:0]}, {224'd0, 32'h01FF_FF00});
    chk(bus_busy_n === 1'b0 && in_ready === 1'b0, "R9 turnaround",
        {254'd0, bus_busy_n, in_ready}, 256'd0);
    @(negedge clk);
    chk(bus_busy_n === 1'b1, "R7 release", {255'd0, bus_busy_n}, 256'd1);

    // R8: stall inside a transfer
    send(make_beat(), 1'b0);
    @(negedge clk);
    chk(bus_drdy_n === 1'b1 && bus_busy_n === 1'b0, "R8 idle clock",
        {254'd0, bus_drdy_n, bus_busy_n}, 256'h2);
    send(make_beat(), 1'b1);

    // Random transfers, lengths 1..6, random gaps
    for (int t = 0; t < 600; t++) begin
      int len;
      len = $urandom_range(6, 1);
      for (int b = 0; b < len; b++) begin
        send(make_beat(), b == len - 1);
        if ($urandom_range(3, 0) == 0) repeat ($urandom_range(2, 1)) @(negedge clk);
      end
      if ($urandom_range(1, 0) == 0) repeat ($urandom_range(3, 0)) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule